// File: doc/BRIEF.md
# Arbitrary Waveform Address Sequencer

This block steps through a small on-chip sample RAM to play back a user-defined waveform. Each RAM word holds one sample value and one end-of-loop flag. While the block is idle, a host loads the RAM and a loop start address. While it runs, every sample-clock tick (a single-cycle `adv` enable on the system clock) reads the sample at the current address into an output register and advances the address by one. The address counter is made of cascaded nibble sections. Each section carries into the next when it is all ones, so the counter performs a plain binary increment.

Playback restarts at the programmed start address in two cases. The first is when the word just read has its end-of-loop flag set. The flagged sample is still played, and the next tick plays the start word. The second is when an external `sync_in` pulse arrives. The counter wraps from all ones to zero when no flag stops it first.

The sample output is a stream with a valid flag and no ready. A downstream converter cannot apply back-pressure: `dac_valid` pulses for one cycle per tick, and each sample must be taken in that cycle. `dac_data` holds its value between ticks. Host inputs are plain controls and take effect only while `run_en` is low.

Top module: `wave_addr_seq`

## Requirements
- R1: After reset, `rd_addr` is 0, `dac_valid` is 0 and `dac_data` is 0.
- R2: While `run_en` is low, the counter is held loaded: one cycle later, `rd_addr` equals the start register as it stood before that edge. A start write (`host_start_we`) therefore shows on `rd_addr` two cycles after it is presented.
- R3: While `run_en` is high, a cycle with `adv` high, `sync_in` low and no end-of-loop flag on the current word makes `rd_addr` increase by exactly one on the next edge. Carries pass across the 4-bit sections.
- R4: While `run_en` is high, a cycle with `adv` and `sync_in` both low leaves `rd_addr` unchanged.
- R5: A tick that reads a word whose flag bit is set (`host_wstop`=1 when it was written) outputs that word's sample. The next `rd_addr` is the start address.
- R6: `sync_in` high while running loads the start address on the next edge. This applies even when `adv` is high in the same cycle, and that tick still outputs the sample at the old address.
- R7: A running tick makes `dac_valid` high for exactly the next cycle, with `dac_data` equal to the sample stored at RAM index `rd_addr[MEM_AW-1:0]` before the edge. In any other cycle `dac_valid` is 0 and `dac_data` keeps its value.
- R8: While `run_en` is high, host writes to the RAM and to the start register have no effect.
- R9: Advancing from address all ones gives address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High: playback runs. Low: host access, counter held at start |
| adv | input | 1 | Sample-clock tick, one cycle wide |
| sync_in | input | 1 | External restart pulse |
| host_we | input | 1 | RAM write strobe (honoured only when idle) |
| host_addr | input | MEM_AW | RAM write index |
| host_wdata | input | SAMPLE_W | Sample value to store |
| host_wstop | input | 1 | End-of-loop flag to store with the sample |
| host_start_we | input | 1 | Start register write strobe (honoured only when idle) |
| host_start | input | ADDR_W | Loop start address |
| rd_addr | output | ADDR_W | Current playback address |
| dac_data | output | SAMPLE_W | Registered sample for the converter |
| dac_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench places the end-of-loop flag where it must restart the loop. A design that restarts one word early would drop the flagged sample, and one that restarts late would play the word after it. The bench raises `sync_in` in the same cycle as a tick; a wrong priority either loses that sample or advances instead of restarting. It starts a loop just below all ones, where a broken carry chain would skip or repeat a nibble and a missing wrap would leave the address stuck. It also writes flagged words ahead of the playback point while running, which a design that fails to block those writes would turn into an early restart.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  // Width of one counter section; the address width must be a multiple of it.
  localparam int unsigned NIB_W = 4;

  function automatic int unsigned sec_count(input int unsigned width);
    return width / NIB_W;
  endfunction
endpackage

// File: rtl/wseq_nib_ctr.sv
module wseq_nib_ctr #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              inc,
  input  logic [ADDR_W-1:0] start,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned NW   = wseq_pkg::NIB_W;
  localparam int unsigned NSEC = wseq_pkg::sec_count(ADDR_W);

  logic [NSEC-1:0] sec_en;
  assign sec_en[0] = inc;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    logic [NW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (load)      q <= start[g*NW +: NW];
      else if (sec_en[g]) q <= q + 1'b1;
    end
    assign addr[g*NW +: NW] = q;
    if (g < NSEC - 1) begin : g_carry
      assign sec_en[g+1] = sec_en[g] & (&q);
    end
  end

  // R3: cascaded sections act as one binary incrementer
  a_r3_binary_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> addr == $past(addr) + 1'b1);
  // R9: all ones rolls over to zero
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (&addr)) |=> addr == '0);
  // R2: load places the start value
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(start));
endmodule

// File: rtl/wseq_sample_ram.sv
module wseq_sample_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 13
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wseq_out_latch.sv
module wseq_out_latch #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= take;
      if (take) dout <= din;
    end
  end

  // R7: one pulse per tick, data steady between ticks
  a_r7_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> valid && dout == $past(din));
  a_r7_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !valid && $stable(dout));
endmodule

// File: rtl/wave_addr_seq.sv
module wave_addr_seq #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned MEM_AW   = 8,
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                adv,
  input  logic                sync_in,
  input  logic                host_we,
  input  logic [MEM_AW-1:0]   host_addr,
  input  logic [SAMPLE_W-1:0] host_wdata,
  input  logic                host_wstop,
  input  logic                host_start_we,
  input  logic [ADDR_W-1:0]   host_start,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                dac_valid
);
  localparam int unsigned WORD_W = SAMPLE_W + 1;  // flag on top of the sample

  logic [ADDR_W-1:0] start_q;
  logic [WORD_W-1:0] rword;
  logic              cur_stop;
  logic              tick;
  logic              reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       start_q <= '0;
    else if (!run_en && host_start_we) start_q <= host_start;
  end

  assign tick     = run_en & adv;
  assign cur_stop = rword[SAMPLE_W];
  assign reload   = !run_en | sync_in | (tick & cur_stop);

  wseq_nib_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (reload),
    .inc   (tick),
    .start (start_q),
    .addr  (rd_addr)
  );

  wseq_sample_ram #(.AW(MEM_AW), .DW(WORD_W)) u_ram (
    .clk   (clk),
    .we    (host_we & !run_en),
    .waddr (host_addr),
    .wdata ({host_wstop, host_wdata}),
    .raddr (rd_addr[MEM_AW-1:0]),
    .rdata (rword)
  );

  wseq_out_latch #(.DW(SAMPLE_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (tick),
    .din   (rword[SAMPLE_W-1:0]),
    .dout  (dac_data),
    .valid (dac_valid)
  );

  // R6: sync restarts at start
  a_r6_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sync_in) |=> rd_addr == $past(start_q));
  // R5: flagged word read on a tick restarts the loop
  a_r5_flag_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur_stop) |=> rd_addr == $past(start_q));
  // R4: no tick, no sync, no movement
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !adv && !sync_in) |=> $stable(rd_addr));
  // R8: start register frozen while running
  a_r8_start_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(start_q));
endmodule

// File: tb/sim_wave_addr_seq.sv
module sim_wave_addr_seq;
  localparam int unsigned AW = 16;
  localparam int unsigned MAW = 8;
  localparam int unsigned SW = 12;
  localparam int unsigned DEPTH = 1 << MAW;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, adv = 1'b0, sync_in = 1'b0;
  logic host_we = 1'b0, host_wstop = 1'b0, host_start_we = 1'b0;
  logic [MAW-1:0] host_addr = '0;
  logic [SW-1:0] host_wdata = '0;
  logic [AW-1:0] host_start = '0;
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] dac_data;
  logic dac_valid;

  int checks = 0;
  int errors = 0;

  logic [SW-1:0] m_s [DEPTH];
  logic          m_stop [DEPTH];
  logic [AW-1:0] m_st = '0;
  logic [AW-1:0] e_addr = '0;
  logic [SW-1:0] e_data = '0;
  logic          e_vld = 1'b0;
  string         tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_addr_seq #(.ADDR_W(AW), .MEM_AW(MAW), .SAMPLE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .adv(adv), .sync_in(sync_in),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wstop(host_wstop), .host_start_we(host_start_we), .host_start(host_start),
    .rd_addr(rd_addr), .dac_data(dac_data), .dac_valid(dac_valid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, predict, then compare at the next falling edge.
  task automatic step(input logic run, input logic a, input logic sy,
                      input logic we, input int wa, input logic [SW-1:0] wd, input logic ws,
                      input logic swe, input logic [AW-1:0] st);
    logic [AW-1:0] old_st;
    logic [MAW-1:0] idx;
    run_en = run; adv = a; sync_in = sy;
    host_we = we; host_addr = MAW'(wa); host_wdata = wd; host_wstop = ws;
    host_start_we = swe; host_start = st;
    old_st = m_st;
    idx = e_addr[MAW-1:0];
    if (!run) begin
      tag = "R2";
      e_vld = 1'b0;
      if (we) begin m_s[MAW'(wa)] = wd; m_stop[MAW'(wa)] = ws; end
      if (swe) m_st = st;
      e_addr = old_st;
    end else begin
      if (we || swe) tag = "R8";
      else if (sy) tag = "R6";
      else if (a && m_stop[idx]) tag = "R5";
      else if (a && (&e_addr)) tag = "R9";
      else if (a) tag = "R3";
      else tag = "R4";
      e_vld = a;
      if (a) e_data = m_s[idx];
      if (sy || (a && m_stop[idx])) e_addr = old_st;
      else if (a) e_addr = e_addr + 1'b1;
    end
    @(negedge clk);
    chk(tag, "rd_addr", 32'(rd_addr), 32'(e_addr));
    chk("R7", "dac_valid", 32'(dac_valid), 32'(e_vld));
    chk("R7", "dac_data", 32'(dac_data), 32'(e_data));
  endtask

  task automatic idle_write(input int wa, input logic [SW-1:0] wd, input logic ws);
    step(1'b0, 1'b0, 1'b0, 1'b1, wa, wd, ws, 1'b0, '0);
  endtask

  task automatic set_start(input logic [AW-1:0] st);
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b1, st);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "rd_addr", 32'(rd_addr), 32'h0);
    chk("R1", "dac_valid", 32'(dac_valid), 32'h0);
    chk("R1", "dac_data", 32'(dac_data), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill RAM, single flag at 20, start at 5 (R2, R5)
    for (int i = 0; i < DEPTH; i++) idle_write(i, SW'($urandom), (i == 20));
    set_start(16'd5);
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, '0);
    run_ticks(40);

    // R4: idle cycles between ticks, R6: sync coinciding with a tick
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, '0);
    run_ticks(3);
    step(1'b1, 1'b1, 1'b1, 1'b0, 0, '0, 1'b0, 1'b0, '0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, '0, 1'b0, 1'b0, '0);
    run_ticks(4);

    // R8: flagged writes ahead of playback and a start write while running
    for (int i = 0; i < 8; i++)
      step(1'b1, 1'b1, 1'b0, 1'b1, int'(rd_addr[MAW-1:0]) + 2, SW'($urandom), 1'b1, 1'b1, 16'h00aa);
    run_ticks(20);

    // R9: wrap from all ones, flag placed after zero
    for (int i = 250; i < DEPTH; i++) idle_write(i, SW'($urandom), 1'b0);
    for (int i = 0; i < 3; i++) idle_write(i, SW'($urandom), 1'b0);
    idle_write(3, SW'($urandom), 1'b1);
    set_start(16'hfffc);
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, '0);
    run_ticks(20);

    // R3 carry across sections: start at 0x0ffe
    idle_write(8'hfe, SW'($urandom), 1'b0);
    idle_write(8'hff, SW'($urandom), 1'b0);
    set_start(16'h0ffe);
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, '0);
    run_ticks(4);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic run;
      logic [AW-1:0] st;
      run = ($urandom % 50) != 0;
      st = (($urandom % 4) == 0) ? (16'hff00 | 16'($urandom % 256)) : 16'($urandom);
      step(run, ($urandom % 2) == 1, ($urandom % 30) == 0,
           ($urandom % 4) == 0, int'($urandom % DEPTH), SW'($urandom), ($urandom % 12) == 0,
           ($urandom % 6) == 0, st);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule